// File: doc/BRIEF.md
# DDR2 Read Burst Sequencer

This block turns read requests for an already-open DDR2 row into READ commands on the memory command and address pins. It then picks the requester's data out of the burst that comes back. Every READ returns a fixed burst of eight beats. The block waits for the programmed CAS latency, which is 2 to 5 clocks with no additive latency. It then samples the returned beats at two per controller clock. Only the beats the requester asked for are forwarded; the rest of the burst is dropped.

Each request carries a bank, a column and the number of wanted beats. The request port is valid/ready. Ready falls after each acceptance and stays low only for as long as the wanted beats need on the data bus. The minimum spacing between READs is two clocks. A request held waiting can therefore issue while the previous burst is still running, and that cuts the previous burst short. The response port has no back-pressure, because a DRAM burst cannot be paused. A consumer must take a response in the cycle it is presented.

The block issues no precharge of any kind, so the row stays open. The CAS latency is set through a plain write strobe. An illegal value, or a write that arrives while any READ is still in flight, leaves the current setting unchanged.

Top module: `rd_burst_seq`

## Requirements
- R1: After reset the command pins show NOP (chip select low; RAS, CAS and WE high), clock enable is high, `req_ready` is 1, `rsp_valid` is 0 and the CAS latency is 3.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) appears on the pins for exactly the next cycle as a READ. In that cycle chip select is low, RAS is high, CAS is low and WE is high. `cmd_ba` carries the bank. `cmd_addr[9:0]` carries column bits [9:0], `cmd_addr[12:11]` carries column bits [11:10], and `cmd_addr[13]` is 0. Every other cycle is a NOP with address and bank at zero.
- R3: A latency write whose value is 2, 3, 4 or 5 replaces the CAS latency. Any other value (0, 1, 6, 7) is ignored, and the latency stays unchanged.
- R4: For a READ on the pins in cycle c, beat pair k (k = 0..3) is sampled from `phy_data` at the end of cycle c+CL+k. `phy_data[31:0]` holds beat 2k and `phy_data[63:32]` holds beat 2k+1.
- R5: With n = `req_len`+1 wanted beats, only beats 0..n-1 are forwarded, one cycle after their pair is sampled. `rsp_beat_en[0]` marks the low beat and `rsp_beat_en[1]` the high beat. `rsp_last` is set with the pair that holds beat n-1. Later beats of the burst are dropped, and `rsp_valid`, `rsp_beat_en` and `rsp_last` are 0 in all other cycles.
- R6: After accepting a request of n beats, `req_ready` stays low so that the next READ comes max(2, ceil(n/2)) clocks after it. A request that is waiting issues at exactly that spacing and truncates the running burst. The truncated burst's trailing beats are not forwarded.
- R7: No command other than READ and NOP is ever driven: RAS stays high, and the auto-precharge bit `cmd_addr[10]` is 0 on every READ.
- R8: A latency write sampled while any READ is in flight, or in the same cycle a request is accepted, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lat_we | input | 1 | CAS latency write strobe |
| cfg_lat_val | input | 3 | CAS latency value to write |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request can be accepted |
| req_bank | input | BANK_W (3) | Bank of the request |
| req_col | input | COL_W (12) | Column of the request |
| req_len | input | 3 | Wanted beats minus one |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_cke | output | 1 | Clock enable |
| cmd_ba | output | BANK_W (3) | Bank address pins |
| cmd_addr | output | ADDR_W (14) | Address pins |
| phy_vld | input | 1 | Returned beat pair present |
| phy_data | input | 2*DATA_W (64) | Returned beat pair, earlier beat low |
| rsp_valid | output | 1 | Response pair valid |
| rsp_data | output | 2*DATA_W (64) | Response beat pair |
| rsp_beat_en | output | 2 | Which beats of the pair are wanted |
| rsp_last | output | 1 | Pair holds the final wanted beat |

## Verification
The assertions check several properties on every cycle. No two READs are adjacent, and ready falls after each acceptance. An accepted request is followed at once by a READ, and NOP cycles carry a cleared address. The auto-precharge bit stays low, and the latency cannot move while reads are in flight. Response flags stay consistent with `rsp_valid`. Only the bench scenarios show the rest: that the data window lands exactly CL clocks after the command for each latency, that the wanted-beat mask and last flag match the request length, that truncation drops the right beats at the right spacing, and that illegal or busy-time latency writes leave the return timing unchanged.

// File: rtl/rdseq_pkg.sv
`timescale 1ns/1ps
package rdseq_pkg;
  localparam int BURST_BEATS   = 8;
  localparam int BEATS_PER_CLK = 2;
  localparam int BURST_CLKS    = BURST_BEATS / BEATS_PER_CLK;
  localparam int LEN_W         = $clog2(BURST_BEATS);
  localparam int LAT_W         = 3;
  localparam int CL_MIN        = 2;
  localparam int CL_MAX        = 5;
  localparam int CL_DEFAULT    = 3;
  localparam int MIN_SPACING   = 2;
  localparam int AP_BIT        = 10;

  function automatic logic lat_legal(input logic [LAT_W-1:0] v);
    return (int'(v) >= CL_MIN) && (int'(v) <= CL_MAX);
  endfunction

  // clocks the wanted beats occupy on the data bus, never below the minimum spacing
  function automatic int spacing_for(input logic [LEN_W-1:0] len);
    int pairs;
    pairs = int'(len) / BEATS_PER_CLK + 1;
    return (pairs < MIN_SPACING) ? MIN_SPACING : pairs;
  endfunction
endpackage

// File: rtl/rd_lat_cfg.sv
`timescale 1ns/1ps
module rd_lat_cfg
  import rdseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LAT_W-1:0] wr_val,
  input  logic             busy,
  output logic [LAT_W-1:0] lat
);
  always_ff @(posedge clk) begin
    if (!rst_n) lat <= LAT_W'(CL_DEFAULT);
    else if (wr_en && !busy && lat_legal(wr_val)) lat <= wr_val;
  end

  AST_LAT_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lat)); // R8
endmodule

// File: rtl/rd_cmd_issue.sv
`timescale 1ns/1ps
module rd_cmd_issue
  import rdseq_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int COL_W  = 12,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  output logic              fire,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic              cmd_cke,
  output logic [BANK_W-1:0] cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr
);
  localparam int GAP_W = $clog2(BURST_CLKS + 1);

  logic [GAP_W-1:0]  gap_cnt;
  logic              rd_q;
  logic [BANK_W-1:0] ba_q;
  logic [ADDR_W-1:0] addr_q;

  // column bits skip the auto-precharge position, which stays clear
  function automatic logic [ADDR_W-1:0] place_col(input logic [COL_W-1:0] c);
    logic [ADDR_W-1:0] a;
    a = '0;
    for (int i = 0; i < COL_W; i++) begin
      if (i < AP_BIT) a[i] = c[i];
      else            a[i+1] = c[i];
    end
    return a;
  endfunction

  assign req_ready = (gap_cnt == '0);
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      rd_q    <= 1'b0;
      ba_q    <= '0;
      addr_q  <= '0;
    end else begin
      if (fire)                 gap_cnt <= GAP_W'(spacing_for(req_len) - 1);
      else if (gap_cnt != '0)   gap_cnt <= gap_cnt - 1'b1;
      rd_q   <= fire;
      ba_q   <= fire ? req_bank : '0;
      addr_q <= fire ? place_col(req_col) : '0;
    end
  end

  assign cmd_cs_n  = 1'b0;
  assign cmd_ras_n = 1'b1;
  assign cmd_we_n  = 1'b1;
  assign cmd_cas_n = ~rd_q;
  assign cmd_cke   = 1'b1;
  assign cmd_ba    = ba_q;
  assign cmd_addr  = addr_q;

  AST_CMD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !cmd_cas_n); // R2
  AST_NOP_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cas_n |-> (cmd_addr == '0 && cmd_ba == '0)); // R2
  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_cas_n |=> cmd_cas_n); // R6
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !req_ready); // R6
  AST_NO_AUTO_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_cas_n |-> !cmd_addr[AP_BIT]); // R7
endmodule

// File: rtl/rd_return_path.sv
`timescale 1ns/1ps
module rd_return_path
  import rdseq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire,
  input  logic [LEN_W-1:0]      req_len,
  input  logic [LAT_W-1:0]      lat,
  input  logic                  phy_vld,
  input  logic [2*DATA_W-1:0]   phy_data,
  output logic                  busy,
  output logic                  rsp_valid,
  output logic [2*DATA_W-1:0]   rsp_data,
  output logic [1:0]            rsp_beat_en,
  output logic                  rsp_last
);
  localparam int NSTG = CL_MAX + BURST_CLKS;
  localparam int K_W  = $clog2(BURST_CLKS);

  // age-indexed tracker: stage j holds the READ issued j cycles ago
  logic [NSTG-1:0]  stg_vld;
  logic [LEN_W-1:0] stg_len [NSTG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_vld <= '0;
      for (int j = 0; j < NSTG; j++) stg_len[j] <= '0;
    end else begin
      stg_vld    <= {stg_vld[NSTG-2:0], fire};
      stg_len[0] <= req_len;
      for (int j = 1; j < NSTG; j++) stg_len[j] <= stg_len[j-1];
    end
  end

  assign busy = |stg_vld;

  logic             hit;
  logic [LEN_W-1:0] sel_len;
  logic [K_W-1:0]   sel_k;
  logic             want_pair, hi_en, is_last;

  // youngest READ whose data window covers this cycle owns the bus
  always_comb begin
    hit     = 1'b0;
    sel_len = '0;
    sel_k   = '0;
    for (int j = NSTG - 1; j >= 0; j--) begin
      if (stg_vld[j] && (j >= int'(lat)) && (j < int'(lat) + BURST_CLKS)) begin
        hit     = 1'b1;
        sel_len = stg_len[j];
        sel_k   = K_W'(j - int'(lat));
      end
    end
  end

  assign want_pair = hit && (sel_k <= sel_len[LEN_W-1:1]);
  assign hi_en     = ({sel_k, 1'b1} <= sel_len);
  assign is_last   = (sel_k == sel_len[LEN_W-1:1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_beat_en <= 2'b00;
      rsp_last    <= 1'b0;
    end else begin
      rsp_valid   <= want_pair && phy_vld;
      rsp_data    <= phy_data;
      rsp_beat_en <= (want_pair && phy_vld) ? {hi_en, 1'b1} : 2'b00;
      rsp_last    <= want_pair && phy_vld && is_last;
    end
  end

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> rsp_valid); // R5
  AST_LOW_BEAT_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_beat_en[0]); // R5
  AST_IDLE_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_beat_en == 2'b00)); // R5
endmodule

// File: rtl/rd_burst_seq.sv
`timescale 1ns/1ps
module rd_burst_seq
  import rdseq_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int COL_W  = 12,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_lat_we,
  input  logic [2:0]          cfg_lat_val,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [COL_W-1:0]    req_col,
  input  logic [2:0]          req_len,
  output logic                cmd_cs_n,
  output logic                cmd_ras_n,
  output logic                cmd_cas_n,
  output logic                cmd_we_n,
  output logic                cmd_cke,
  output logic [BANK_W-1:0]   cmd_ba,
  output logic [ADDR_W-1:0]   cmd_addr,
  input  logic                phy_vld,
  input  logic [2*DATA_W-1:0] phy_data,
  output logic                rsp_valid,
  output logic [2*DATA_W-1:0] rsp_data,
  output logic [1:0]          rsp_beat_en,
  output logic                rsp_last
);
  logic             fire;
  logic             ret_busy;
  logic [LAT_W-1:0] lat;

  rd_lat_cfg u_lat (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_lat_we),
    .wr_val (cfg_lat_val),
    .busy   (ret_busy || fire),
    .lat    (lat)
  );

  rd_cmd_issue #(.BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bank  (req_bank),
    .req_col   (req_col),
    .req_len   (req_len),
    .fire      (fire),
    .cmd_cs_n  (cmd_cs_n),
    .cmd_ras_n (cmd_ras_n),
    .cmd_cas_n (cmd_cas_n),
    .cmd_we_n  (cmd_we_n),
    .cmd_cke   (cmd_cke),
    .cmd_ba    (cmd_ba),
    .cmd_addr  (cmd_addr)
  );

  rd_return_path #(.DATA_W(DATA_W)) u_ret (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .req_len     (req_len),
    .lat         (lat),
    .phy_vld     (phy_vld),
    .phy_data    (phy_data),
    .busy        (ret_busy),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_beat_en (rsp_beat_en),
    .rsp_last    (rsp_last)
  );
endmodule

// File: tb/tb_rd_burst_seq.sv
`timescale 1ns/1ps
module tb_rd_burst_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cfg_lat_we = 1'b0;
  logic [2:0]  cfg_lat_val = 3'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_bank = '0;
  logic [11:0] req_col = '0;
  logic [2:0]  req_len = '0;
  logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_cke;
  logic [2:0]  cmd_ba;
  logic [13:0] cmd_addr;
  logic        phy_vld = 1'b0;
  logic [63:0] phy_data = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic [1:0]  rsp_beat_en;
  logic        rsp_last;

  rd_burst_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_lat_we(cfg_lat_we), .cfg_lat_val(cfg_lat_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_col(req_col), .req_len(req_len), .cmd_cs_n(cmd_cs_n),
    .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_cke(cmd_cke), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
    .phy_vld(phy_vld), .phy_data(phy_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_beat_en(rsp_beat_en), .rsp_last(rsp_last)
  );

  typedef struct packed {
    logic [2:0]  cl;
    logic [3:0]  idle;
    logic [2:0]  bank;
    logic [11:0] col;
    logic [2:0]  len;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{3'd3, 4'd2, 3'd1, 12'h3FF, 3'd7},
    '{3'd3, 4'd0, 3'd2, 12'h400, 3'd0},
    '{3'd3, 4'd0, 3'd3, 12'h801, 3'd3},
    '{3'd3, 4'd0, 3'd4, 12'hC00, 3'd4},
    '{3'd3, 4'd0, 3'd5, 12'h0F0, 3'd1},
    '{3'd2, 4'd5, 3'd6, 12'h555, 3'd6},
    '{3'd2, 4'd0, 3'd7, 12'hAAA, 3'd2},
    '{3'd5, 4'd5, 3'd0, 12'h123, 3'd5},
    '{3'd5, 4'd0, 3'd1, 12'h7FE, 3'd3},
    '{3'd5, 4'd0, 3'd2, 12'hFFF, 3'd7},
    '{3'd4, 4'd3, 3'd3, 12'h246, 3'd2},
    '{3'd4, 4'd0, 3'd4, 12'h9B1, 3'd0}
  };

  int n_run = 0;
  int n_fail = 0;
  int tb_cl = 3;
  int cyc = 0;
  bit done = 1'b0;

  logic [2:0]  q_bank [64];
  logic [11:0] q_col  [64];
  logic [2:0]  q_len  [64];
  bit          q_b2b  [64];
  int q_wr = 0;
  int q_rd = 0;
  int last_rd_cyc = 0;
  int prev_len = 0;
  int burst_id = 0;

  logic        mem_v [16];
  logic [63:0] mem_d [16];
  logic        exp_v [16];
  logic [1:0]  exp_en [16];
  logic        exp_last [16];
  logic [63:0] exp_d [16];

  function automatic logic [31:0] beat_word(input int id, input int b);
    return {8'hA5, 8'(id), 8'h00, 8'(b)};
  endfunction

  function automatic logic [13:0] addr_of(input logic [11:0] c);
    return {1'b0, c[11:10], 1'b0, c[9:0]};
  endfunction

  function automatic int gap_of(input int len);
    return ((len / 2 + 1) < 2) ? 2 : (len / 2 + 1);
  endfunction

  // memory model, pin monitor and response scoreboard, all mid-cycle
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cmd_cas_n == 1'b0) begin
        n_run++;
        if (cmd_cs_n !== 1'b0 || cmd_ras_n !== 1'b1 || cmd_we_n !== 1'b1 ||
            cmd_ba !== q_bank[q_rd] || cmd_addr !== addr_of(q_col[q_rd]))
        begin
          n_fail++;
          $display("FAIL R2 R7 read cmd: cs/ras/we=%b%b%b ba=%h addr=%h, expected 011 ba=%h addr=%h",
                   cmd_cs_n, cmd_ras_n, cmd_we_n, cmd_ba, cmd_addr, q_bank[q_rd], addr_of(q_col[q_rd]));
        end
        if (q_b2b[q_rd]) begin
          n_run++;
          if (cyc - last_rd_cyc != gap_of(prev_len)) begin
            n_fail++;
            $display("FAIL R6 read spacing: got %0d expected %0d", cyc - last_rd_cyc, gap_of(prev_len));
          end
        end
        for (int k = 0; k < 4; k++) begin
          mem_v[tb_cl + k] = 1'b1;
          mem_d[tb_cl + k] = {beat_word(burst_id, 2 * k + 1), beat_word(burst_id, 2 * k)};
          if (2 * k <= int'(q_len[q_rd])) begin
            exp_v[tb_cl + k + 1]    = 1'b1;
            exp_en[tb_cl + k + 1]   = {(2 * k + 1 <= int'(q_len[q_rd])), 1'b1};
            exp_last[tb_cl + k + 1] = (k == int'(q_len[q_rd]) / 2);
            exp_d[tb_cl + k + 1]    = mem_d[tb_cl + k];
          end
        end
        prev_len = int'(q_len[q_rd]);
        last_rd_cyc = cyc;
        burst_id++;
        q_rd++;
      end else begin
        n_run++;
        if (cmd_cs_n !== 1'b0 || cmd_ras_n !== 1'b1 || cmd_we_n !== 1'b1 ||
            cmd_cke !== 1'b1 || cmd_addr !== '0 || cmd_ba !== '0) begin
          n_fail++;
          $display("FAIL R2 R7 nop: cs/ras/cas/we/cke=%b%b%b%b%b addr=%h, expected 01111 addr=0",
                   cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_cke, cmd_addr);
        end
      end
    end
    phy_vld  = mem_v[0];
    phy_data = mem_d[0];
    for (int i = 0; i < 15; i++) begin
      mem_v[i] = mem_v[i+1];
      mem_d[i] = mem_d[i+1];
    end
    mem_v[15] = 1'b0;
    mem_d[15] = '0;
    if (rst_n && (exp_v[0] || rsp_valid)) begin
      n_run++;
      if (rsp_valid !== exp_v[0] ||
          (exp_v[0] && (rsp_beat_en !== exp_en[0] || rsp_last !== exp_last[0] ||
                        rsp_data[31:0] !== exp_d[0][31:0] ||
                        (exp_en[0][1] && rsp_data[63:32] !== exp_d[0][63:32])))) begin
        n_fail++;
        $display("FAIL R4 R5 response: v=%b en=%b last=%b d=%h, expected v=%b en=%b last=%b d=%h",
                 rsp_valid, rsp_beat_en, rsp_last, rsp_data,
                 exp_v[0], exp_en[0], exp_last[0], exp_d[0]);
      end
    end
    for (int i = 0; i < 15; i++) begin
      exp_v[i] = exp_v[i+1];
      exp_en[i] = exp_en[i+1];
      exp_last[i] = exp_last[i+1];
      exp_d[i] = exp_d[i+1];
    end
    exp_v[15] = 1'b0;
    exp_en[15] = 2'b00;
    exp_last[15] = 1'b0;
    exp_d[15] = '0;
  end

  // called at a negedge; returns at the negedge after acceptance
  task automatic send(input logic [2:0] bank, input logic [11:0] col,
                      input logic [2:0] len, input bit b2b);
    req_valid = 1'b1;
    req_bank  = bank;
    req_col   = col;
    req_len   = len;
    while (!req_ready) @(negedge clk);
    q_bank[q_wr] = bank;
    q_col[q_wr]  = col;
    q_len[q_wr]  = len;
    q_b2b[q_wr]  = b2b;
    q_wr++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic write_lat(input logic [2:0] v, input bit in_flight);
    cfg_lat_we  = 1'b1;
    cfg_lat_val = v;
    @(negedge clk);
    cfg_lat_we = 1'b0;
    if (!in_flight && int'(v) >= 2 && int'(v) <= 5) tb_cl = int'(v);
  endtask

  task automatic print_summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem_v[i] = 1'b0; mem_d[i] = '0;
      exp_v[i] = 1'b0; exp_en[i] = 2'b00; exp_last[i] = 1'b0; exp_d[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    n_run++;
    if (cmd_cs_n !== 1'b0 || cmd_ras_n !== 1'b1 || cmd_cas_n !== 1'b1 || cmd_we_n !== 1'b1 ||
        cmd_cke !== 1'b1 || req_ready !== 1'b1 || rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: cs/ras/cas/we/cke=%b%b%b%b%b ready=%b rsp_valid=%b, expected 01111 1 0",
               cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_cke, req_ready, rsp_valid);
    end

    // table walk: default latency 3 (R1 R3), spacing and truncation (R6), masks (R5)
    for (int i = 0; i < NVEC; i++) begin
      if (int'(VECS[i].cl) != tb_cl) begin
        repeat (20) @(negedge clk);
        write_lat(VECS[i].cl, 1'b0);
      end
      repeat (int'(VECS[i].idle)) @(negedge clk);
      send(VECS[i].bank, VECS[i].col, VECS[i].len, (VECS[i].idle == 0));
    end

    // R3: illegal latency values are ignored; return timing stays at the current latency
    repeat (20) @(negedge clk);
    write_lat(3'd0, 1'b0);
    write_lat(3'd1, 1'b0);
    write_lat(3'd6, 1'b0);
    write_lat(3'd7, 1'b0);
    repeat (2) @(negedge clk);
    send(3'd5, 12'h3C3, 3'd7, 1'b0);

    // R3: a legal value while idle takes effect
    repeat (20) @(negedge clk);
    write_lat(3'd2, 1'b0);
    repeat (2) @(negedge clk);
    send(3'd6, 12'h00A, 3'd7, 1'b0);

    // R8: a write while a READ is in flight is ignored
    write_lat(3'd5, 1'b1);
    repeat (3) @(negedge clk);
    send(3'd7, 12'h5A5, 3'd3, 1'b0);
    send(3'd0, 12'hA5A, 3'd5, 1'b1);

    repeat (30) @(negedge clk);
    done = 1'b1;
    print_summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      print_summary();
      $finish;
    end
  end
endmodule